// File: doc/BRIEF.md
# Wakeup Supervision and Acknowledge Tracker

This block watches the span of time that begins when the chip drops into a low-power state and ends when wakeup is declared complete. It works in three phases. While the chip runs it does nothing. After a low-power entry pulse it times the wait for a wakeup event. Once that event arrives, or once a timeout forces it, it times the wakeup itself. It declares wakeup complete on one of two conditions, chosen by a select bit: the chip reports that it has reached run, or every CPU marked active has written its acknowledge.

It collects a one-bit acknowledge from each of five cores. It has three separate watchdog windows: low-power to wakeup, wakeup to all-acknowledged, and wakeup to run. An expired window sets a sticky timeout flag and raises an error interrupt for each core that enables it. A normal wakeup interrupt goes to each core that enables it at the moment of completion. All status bits stay set until software clears them with a write-one-to-clear. The system mode state machine and the routing of wakeup sources are outside this block.

Top module: `wake_supervisor`

## Requirements
- R1: After reset, `phase` is 0 (run), and `ack_vec`, `tout_flags`, `err_irq`, `wk_irq`, `force_wake` and `wake_done` are all 0.
- R2: Phase encoding is 0 = run, 1 = waiting for wakeup, 2 = waking. A `lp_entry` sampled in run moves the phase to 1 at that edge. `lp_entry` is ignored in phases 1 and 2, and `wake_evt` is ignored in phase 0.
- R3: The phase counter is 0 in the first cycle of phase 1. If no `wake_evt` is sampled while the counter equals `lp_limit`, the low-power window expires at that edge, at most once per phase. With `lp_wdt_en` set, expiry sets `tout_flags[0]`. For `lp_limit` = L with entry at edge E, the flag is visible after edge E+L+1 and not after edge E+L.
- R4: If the low-power window expires with `lp_force_en` set, the phase moves to 2 at that edge and `force_wake` is high for exactly the following cycle. With `lp_force_en` clear, the phase stays at 1.
- R5: A `wake_evt` sampled in phase 1 moves the phase to 2 and restarts the counter at 0.
- R6: With `done_sel` = 0, `chip_run` high in phase 2 completes wakeup. The phase returns to 0 at that edge, and `wake_done` is high for the following cycle.
- R7: `ack_vec` bit i belongs to core i (bits 0 to 4). A bit is set by `ack_set[i]`. `ack_clr_all` clears every bit, and a set in the same cycle wins. `all_acked` is 1 when every core with `core_active` set has its bit set, so inactive cores count as acknowledged. With `done_sel` = 1, `all_acked` in phase 2 completes wakeup.
- R8: With `wk_wdt_en` set, in phase 2, the acknowledge window expires when the counter equals `ack_limit` while `all_acked` is low. This sets `tout_flags[1]`. The run window expires when the counter equals `run_limit` while `chip_run` is low, and sets `tout_flags[2]`. Neither expires in the cycle where wakeup completes.
- R9: Every timeout flag that is set raises `err_irq[i]` for each core with `err_irq_en[i]` set.
- R10: When wakeup completes, `wk_irq[i]` is set for each core with `wk_irq_en[i]` set.
- R11: `err_irq`, `wk_irq` and `tout_flags` are sticky. `irq_clr[i]` clears `err_irq[i]` and `wk_irq[i]`, and `tout_clr[k]` clears `tout_flags[k]`. A set in the same cycle wins over a clear.
- R12: The counter restarts from 0 on every phase change, so a second low-power entry after completion sees the same window timing as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_entry | input | 1 | Pulse: chip entered low power |
| wake_evt | input | 1 | Pulse: wakeup event received |
| chip_run | input | 1 | Level: chip has reached run |
| done_sel | input | 1 | Completion source: 0 chip run, 1 all active acknowledged |
| core_active | input | 5 | Cores taking part in the acknowledge check |
| ack_set | input | 5 | Per-core acknowledge set strobes |
| ack_clr_all | input | 1 | Clear all acknowledges |
| lp_limit | input | 16 | Low-power to wakeup window |
| lp_wdt_en | input | 1 | Flag expiry of the low-power window |
| lp_force_en | input | 1 | Force wakeup on low-power window expiry |
| ack_limit | input | 16 | Wakeup to all-acknowledged window |
| run_limit | input | 16 | Wakeup to run window |
| wk_wdt_en | input | 1 | Enable the two wakeup-phase windows |
| err_irq_en | input | 5 | Per-core error interrupt enable |
| wk_irq_en | input | 5 | Per-core wakeup interrupt enable |
| irq_clr | input | 5 | Per-core write-one-to-clear of both interrupts |
| tout_clr | input | 3 | Write-one-to-clear of timeout flags |
| phase | output | 2 | Current phase |
| ack_vec | output | 5 | Collected acknowledges |
| all_acked | output | 1 | Every active core acknowledged |
| force_wake | output | 1 | Pulse: wakeup forced by timeout |
| wake_done | output | 1 | Pulse: wakeup completed |
| tout_flags | output | 3 | Sticky flags: bit0 low-power, bit1 acknowledge, bit2 run |
| err_irq | output | 5 | Sticky per-core error interrupts |
| wk_irq | output | 5 | Sticky per-core wakeup interrupts |

## Verification
The properties assume that the configuration inputs (limits, enables, `done_sel`, `core_active`) are held steady while a phase is in progress. They also assume that `lp_entry` and `wake_evt` are single-cycle pulses. The stimulus changes configuration only while the block is in run or waiting, or on the negative edge just after a phase change. It drives every pulse for exactly one cycle, so each timeout lands on an edge that can be computed from the limits.

// File: rtl/wks_pkg.sv
package wks_pkg;
  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_LPWAIT = 2'd1,
    PH_WAKE   = 2'd2
  } phase_e;

  localparam int unsigned TO_LP  = 0;
  localparam int unsigned TO_ACK = 1;
  localparam int unsigned TO_RUN = 2;
  localparam int unsigned NTOUT  = 3;
endpackage

// File: rtl/wk_phase_fsm.sv
module wk_phase_fsm
  import wks_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_entry,
  input  logic             wake_evt,
  input  logic             done_cond,
  input  logic             all_acked,
  input  logic             chip_run,
  input  logic [TW-1:0]    lp_limit,
  input  logic [TW-1:0]    ack_limit,
  input  logic [TW-1:0]    run_limit,
  input  logic             lp_wdt_en,
  input  logic             lp_force_en,
  input  logic             wk_wdt_en,
  output phase_e           phase,
  output logic [NTOUT-1:0] tout_evt,
  output logic             force_go,
  output logic             done_go
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  function automatic logic [TW-1:0] sat_inc(input logic [TW-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  phase_e           nxt;
  logic [TW-1:0]    cnt;
  logic [NTOUT-1:0] fired;
  logic             in_lp, in_wk, lp_hit, ack_hit, run_hit;

  assign in_lp   = (phase == PH_LPWAIT);
  assign in_wk   = (phase == PH_WAKE);
  assign done_go = in_wk && done_cond;
  assign lp_hit  = in_lp && !wake_evt && (cnt == lp_limit) && !fired[TO_LP];
  assign ack_hit = in_wk && !done_go && !all_acked && (cnt == ack_limit) && !fired[TO_ACK];
  assign run_hit = in_wk && !done_go && !chip_run && (cnt == run_limit) && !fired[TO_RUN];
  assign force_go = lp_hit && lp_force_en;

  always_comb begin
    tout_evt         = '0;
    tout_evt[TO_LP]  = lp_hit && lp_wdt_en;
    tout_evt[TO_ACK] = ack_hit && wk_wdt_en;
    tout_evt[TO_RUN] = run_hit && wk_wdt_en;
  end

  always_comb begin
    nxt = phase;
    case (phase)
      PH_RUN:    if (lp_entry) nxt = PH_LPWAIT;
      PH_LPWAIT: if (wake_evt || force_go) nxt = PH_WAKE;
      PH_WAKE:   if (done_go) nxt = PH_RUN;
      default:   nxt = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_RUN;
      cnt   <= '0;
      fired <= '0;
    end else begin
      phase <= nxt;
      if (nxt != phase || phase == PH_RUN) begin
        cnt   <= '0;
        fired <= '0;
      end else begin
        cnt   <= sat_inc(cnt);
        fired <= fired | {run_hit, ack_hit, lp_hit};
      end
    end
  end
endmodule

// File: rtl/wk_ack_collect.sv
module wk_ack_collect #(
  parameter int unsigned NC = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] ack_set,
  input  logic          ack_clr_all,
  input  logic [NC-1:0] core_active,
  output logic [NC-1:0] ack_vec,
  output logic          all_acked
);
  function automatic logic covered(input logic [NC-1:0] acks, input logic [NC-1:0] act);
    return &(acks | ~act);
  endfunction

  for (genvar i = 0; i < NC; i++) begin : g_ack
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ack_vec[i] <= 1'b0;
      else if (ack_set[i]) ack_vec[i] <= 1'b1;
      else if (ack_clr_all) ack_vec[i] <= 1'b0;
    end
  end

  assign all_acked = covered(ack_vec, core_active);
endmodule

// File: rtl/wk_irq_status.sv
module wk_irq_status #(
  parameter int unsigned NC = 5,
  parameter int unsigned NT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] tout_evt,
  input  logic          done_go,
  input  logic [NC-1:0] err_irq_en,
  input  logic [NC-1:0] wk_irq_en,
  input  logic [NC-1:0] irq_clr,
  input  logic [NT-1:0] tout_clr,
  output logic [NT-1:0] tout_flags,
  output logic [NC-1:0] err_irq,
  output logic [NC-1:0] wk_irq
);
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  logic err_evt;
  assign err_evt = |tout_evt;

  for (genvar k = 0; k < NT; k++) begin : g_tout
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tout_flags[k] <= 1'b0;
      else        tout_flags[k] <= sticky_next(tout_flags[k], tout_evt[k], tout_clr[k]);
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_core
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        err_irq[i] <= 1'b0;
        wk_irq[i]  <= 1'b0;
      end else begin
        err_irq[i] <= sticky_next(err_irq[i], err_evt && err_irq_en[i], irq_clr[i]);
        wk_irq[i]  <= sticky_next(wk_irq[i], done_go && wk_irq_en[i], irq_clr[i]);
      end
    end
  end
endmodule

// File: rtl/wake_supervisor.sv
module wake_supervisor
  import wks_pkg::*;
#(
  parameter int unsigned NC = 5,
  parameter int unsigned TW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_entry,
  input  logic             wake_evt,
  input  logic             chip_run,
  input  logic             done_sel,
  input  logic [NC-1:0]    core_active,
  input  logic [NC-1:0]    ack_set,
  input  logic             ack_clr_all,
  input  logic [TW-1:0]    lp_limit,
  input  logic             lp_wdt_en,
  input  logic             lp_force_en,
  input  logic [TW-1:0]    ack_limit,
  input  logic [TW-1:0]    run_limit,
  input  logic             wk_wdt_en,
  input  logic [NC-1:0]    err_irq_en,
  input  logic [NC-1:0]    wk_irq_en,
  input  logic [NC-1:0]    irq_clr,
  input  logic [NTOUT-1:0] tout_clr,
  output logic [1:0]       phase,
  output logic [NC-1:0]    ack_vec,
  output logic             all_acked,
  output logic             force_wake,
  output logic             wake_done,
  output logic [NTOUT-1:0] tout_flags,
  output logic [NC-1:0]    err_irq,
  output logic [NC-1:0]    wk_irq
);
  phase_e           ph;
  logic [NTOUT-1:0] tout_evt;
  logic             force_go, done_go, done_cond;

  assign done_cond = done_sel ? all_acked : chip_run;
  assign phase     = ph;

  wk_ack_collect #(.NC(NC)) u_ack (
    .clk(clk), .rst_n(rst_n), .ack_set(ack_set), .ack_clr_all(ack_clr_all),
    .core_active(core_active), .ack_vec(ack_vec), .all_acked(all_acked)
  );

  wk_phase_fsm #(.TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .lp_entry(lp_entry), .wake_evt(wake_evt),
    .done_cond(done_cond), .all_acked(all_acked), .chip_run(chip_run),
    .lp_limit(lp_limit), .ack_limit(ack_limit), .run_limit(run_limit),
    .lp_wdt_en(lp_wdt_en), .lp_force_en(lp_force_en), .wk_wdt_en(wk_wdt_en),
    .phase(ph), .tout_evt(tout_evt), .force_go(force_go), .done_go(done_go)
  );

  wk_irq_status #(.NC(NC), .NT(NTOUT)) u_irq (
    .clk(clk), .rst_n(rst_n), .tout_evt(tout_evt), .done_go(done_go),
    .err_irq_en(err_irq_en), .wk_irq_en(wk_irq_en), .irq_clr(irq_clr),
    .tout_clr(tout_clr), .tout_flags(tout_flags), .err_irq(err_irq), .wk_irq(wk_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_wake <= 1'b0;
      wake_done  <= 1'b0;
    end else begin
      force_wake <= force_go;
      wake_done  <= done_go;
    end
  end
endmodule

// File: rtl/wake_supervisor_sva.sv
module wake_supervisor_sva #(
  parameter int unsigned NC = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_clr_all,
  input logic [NC-1:0] err_irq_en,
  input logic [2:0]    tout_clr,
  input logic [1:0]    phase,
  input logic [NC-1:0] ack_vec,
  input logic          force_wake,
  input logic          wake_done,
  input logic [2:0]    tout_flags,
  input logic [NC-1:0] err_irq,
  input logic [NC-1:0] wk_irq
);
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3); // R2
  AST_FORCE_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    force_wake |-> phase == 2'd2); // R4
  AST_DONE_RETURNS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (phase == 2'd0 && $past(phase) == 2'd2)); // R6
  AST_ACK_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ack_clr_all) |-> ((ack_vec & $past(ack_vec)) == $past(ack_vec))); // R7
  AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_irq & ~$past(err_irq) & ~$past(err_irq_en)) == '0)); // R9
  AST_WK_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((wk_irq & ~$past(wk_irq)) != '0) |-> wake_done); // R10
  AST_TOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(tout_flags) & ~tout_flags & ~$past(tout_clr)) == 3'b000)); // R11
  AST_ERR_RISE_FROM_TOUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_irq & ~$past(err_irq)) != '0) |-> (tout_flags != 3'b000)); // R9
endmodule

bind wake_supervisor wake_supervisor_sva #(.NC(NC)) u_sva (
  .clk(clk), .rst_n(rst_n), .ack_clr_all(ack_clr_all), .err_irq_en(err_irq_en),
  .tout_clr(tout_clr), .phase(phase), .ack_vec(ack_vec), .force_wake(force_wake),
  .wake_done(wake_done), .tout_flags(tout_flags), .err_irq(err_irq), .wk_irq(wk_irq)
);

// File: tb/sim_wake_supervisor.sv
module sim_wake_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 5;
  localparam int TW = 16;
  localparam int NTBL = 7;
  // {core_active, ack pattern, expected all_acked}
  localparam logic [10:0] ACK_TBL [NTBL] = '{
    {5'h1F, 5'h1F, 1'b1}, {5'h1F, 5'h0F, 1'b0}, {5'h05, 5'h05, 1'b1},
    {5'h05, 5'h04, 1'b0}, {5'h00, 5'h00, 1'b1}, {5'h12, 5'h13, 1'b1},
    {5'h18, 5'h08, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic lp_entry = 0, wake_evt = 0, chip_run = 0, done_sel = 0, ack_clr_all = 0;
  logic [NC-1:0] core_active = '1, ack_set = '0, err_irq_en = '0, wk_irq_en = '0, irq_clr = '0;
  logic [TW-1:0] lp_limit = 16'd4, ack_limit = 16'd3, run_limit = 16'd5;
  logic lp_wdt_en = 1, lp_force_en = 0, wk_wdt_en = 0;
  logic [2:0] tout_clr = '0;
  logic [1:0] phase;
  logic [NC-1:0] ack_vec, err_irq, wk_irq;
  logic all_acked, force_wake, wake_done;
  logic [2:0] tout_flags;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_supervisor #(.NC(NC), .TW(TW)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    // R1 reset state
    check("R1 phase", phase, 0);
    check("R1 status", {ack_vec, tout_flags, err_irq, wk_irq, force_wake, wake_done}, 0);

    // R7 acknowledge table
    for (int t = 0; t < NTBL; t++) begin
      ack_clr_all = 1; core_active = ACK_TBL[t][10:6];
      step(1);
      ack_clr_all = 0; ack_set = ACK_TBL[t][5:1];
      step(1);
      ack_set = '0;
      check("R7 ack_vec", ack_vec, ACK_TBL[t][5:1]);
      check("R7 all_acked", all_acked, ACK_TBL[t][0]);
    end
    ack_clr_all = 1; ack_set = 5'h01;
    step(1);
    ack_clr_all = 0; ack_set = '0;
    check("R7 set wins over clear", ack_vec, 5'h01);
    core_active = '1; ack_clr_all = 1;
    step(1);
    ack_clr_all = 0;

    // R2 wake_evt ignored in run
    wake_evt = 1; step(1); wake_evt = 0;
    check("R2 wake ignored in run", phase, 0);

    // R3 low-power window, R9 error irq
    err_irq_en = 5'b00101;
    lp_entry = 1; step(1); lp_entry = 0;
    check("R2 enter lp wait", phase, 1);
    step(4);
    check("R3 not yet expired", tout_flags[0], 0);
    step(1);
    check("R3 expired", tout_flags[0], 1);
    check("R9 error irq", err_irq, 5'b00101);
    check("R4 no force stays waiting", phase, 1);
    lp_entry = 1; step(1); lp_entry = 0;
    check("R2 lp_entry ignored in wait", phase, 1);

    // R5 wake event, R6 done via chip run, R10
    wake_evt = 1; step(1); wake_evt = 0;
    check("R5 wake phase", phase, 2);
    lp_entry = 1; step(1); lp_entry = 0;
    check("R2 lp_entry ignored in wake", phase, 2);
    wk_irq_en = 5'b11000; chip_run = 1;
    step(1);
    chip_run = 0;
    check("R6 back to run", phase, 0);
    check("R6 done pulse", wake_done, 1);
    check("R10 wake irq", wk_irq, 5'b11000);
    check("R8 no wake timeouts when disabled", tout_flags[2:1], 0);
    step(1);
    check("R6 done pulse ends", wake_done, 0);

    // R11 write-one-to-clear
    tout_clr = 3'b001; irq_clr = 5'b01001;
    step(1);
    tout_clr = '0; irq_clr = '0;
    check("R11 tout cleared", tout_flags, 0);
    check("R11 err partial clear", err_irq, 5'b00100);
    check("R11 wk partial clear", wk_irq, 5'b10000);
    irq_clr = '1; step(1); irq_clr = '0;
    check("R11 all cleared", {err_irq, wk_irq}, 0);

    // R4 forced wake
    lp_force_en = 1; lp_wdt_en = 0; lp_limit = 16'd2;
    lp_entry = 1; step(1); lp_entry = 0;
    step(2);
    check("R4 before expiry", {phase, force_wake}, {2'd1, 1'b0});
    step(1);
    check("R4 forced to wake", phase, 2);
    check("R4 force pulse", force_wake, 1);
    check("R3 flag off without watchdog", tout_flags[0], 0);
    // R8 wakeup windows, count starts at 0 at the force edge
    wk_wdt_en = 1; ack_clr_all = 1; err_irq_en = 5'b00010; done_sel = 1; wk_irq_en = 5'b00001;
    step(1);
    ack_clr_all = 0;
    check("R4 force pulse ends", force_wake, 0);
    step(2);
    check("R8 ack window open", tout_flags[1], 0);
    step(1);
    check("R8 ack timeout", tout_flags[1], 1);
    check("R9 error irq on ack timeout", err_irq, 5'b00010);
    step(1);
    check("R8 run window open", tout_flags[2], 0);
    step(1);
    check("R8 run timeout", tout_flags[2], 1);
    // R7 done via acknowledges
    ack_set = 5'h1F; step(1); ack_set = '0;
    check("R7 still waking", phase, 2);
    step(1);
    check("R7 done by acks", {phase, wake_done}, {2'd0, 1'b1});
    check("R10 wake irq on ack done", wk_irq, 5'b00001);

    // R12 counter restarts
    tout_clr = '1; lp_force_en = 0; lp_wdt_en = 1; lp_limit = 16'd4;
    step(1); tout_clr = '0;
    lp_entry = 1; step(1); lp_entry = 0;
    step(4);
    check("R12 restarted window open", tout_flags[0], 0);
    step(1);
    check("R12 restarted window expired", tout_flags[0], 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule